// File: doc/BRIEF.md
# Debug System Bus Access Engine

This block lets a debug host reach system memory without involving a processor core. The host sees three registers through a simple register port: control/status, address and data. Accesses to those registers can start 32-bit single-beat cycles on a memory-side request/ready/response interface. The host can therefore move a word, or stream a block of words, with one register access per word.

There are three automation options. A read can start when the address register is written. The next read can start when the data register is read, so the host always receives the word that was fetched by the previous access. The address can also advance by one word after each successful cycle. Two sticky error bits protect the host from silent corruption. One records an access that was attempted while a cycle was still in flight. The other records a bus error response or an unsupported access size. Either bit blocks new cycles until the host clears it.

Register offsets on `reg_addr`: 0 is control/status, 1 is address, 2 is data, and 3 reads as zero. Control/status bit fields:
- `[2:0]` access size
- `[3]` read on address write
- `[4]` read on data read
- `[5]` auto-increment
- `[8]` busy (read-only)
- `[9]` busy error (write 1 to clear)
- `[10]` bus error (write 1 to clear)

Top module: `sba_engine`

## Requirements
- R1: After reset the control/status register reads 0x00000002 (size field 2, every flag and error bit 0), the address and data registers read 0, and `mem_req` is low.
- R2: With size field 2, writing the data register stores the value and issues one bus write (`mem_we`=1) of that value at the current address.
- R3: With bit 3 set, writing the address register issues a bus read at the newly written address, and the data register takes the response data when the response arrives.
- R4: With bit 4 set, reading the data register returns the value held before the read and then issues a bus read at the current address.
- R5: With bit 5 set, the address register advances by 4 only when a cycle completes without error. With bit 5 clear, or on an error response, the address is left unchanged.
- R6: Busy (bit 8) reads 1 from the cycle after a bus cycle is launched until its response has been taken, and 0 otherwise.
- R7: An address write, a data write or a data read made while busy is dropped and sets bit 9. Writing 1 to bit 9 clears it. While bit 9 is set, no new bus cycle is issued.
- R8: An error response sets bit 10 and leaves the data register unchanged. While bit 10 is set, address and data accesses issue no bus cycle and do not change the registers. Writing 1 to bit 10 clears it.
- R9: An access that would launch a cycle while the size field is not 2 issues no bus cycle and sets bit 10.
- R10: While `mem_req` is high and `mem_ready` is low, the request stays asserted and its address, data and direction hold steady.
- R11: After bit 4 has been cleared, a data read returns the last fetched word and issues no bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Host register access strobe, one cycle per access |
| reg_write | input | 1 | 1 for a write, 0 for a read |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read data of the register addressed (combinational) |
| mem_req | output | 1 | Bus request valid |
| mem_we | output | 1 | Bus request is a write |
| mem_addr | output | 32 | Bus byte address |
| mem_wdata | output | 32 | Bus write data |
| mem_ready | input | 1 | Bus accepts the request this cycle |
| mem_rsp_valid | input | 1 | Bus response valid |
| mem_rsp_data | input | 32 | Bus read data |
| mem_rsp_err | input | 1 | Bus response reports an error |

## Verification
The hardest situation to reach from the ports is a host access that lands while a cycle is still outstanding. It takes a slow memory and back-to-back register accesses. The bench raises the memory model's acceptance latency to three cycles and issues an address write immediately after a data write, so the second access falls inside the busy window. The bench then checks that the address was not changed and that the blocked state suppresses a further write. The streaming read is swept word by word with all three automation bits set, followed by a final read after the control register is cleared. Latency is swept across the single-write sweep.

// File: rtl/sba_engine.sv
module sba_engine #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_valid,
  input  logic          reg_write,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ready,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  input  logic          mem_rsp_err
);
  localparam int STEP = DW / 8;
  localparam logic [2:0] SIZE_CODE = 3'($clog2(STEP));

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;
  st_t st;

  logic [2:0]    ctl_size;
  logic          ctl_roa, ctl_rod, ctl_inc;
  logic          err_busy, err_bus;
  logic          op_we;
  logic [AW-1:0] addr_q, req_addr;
  logic [DW-1:0] data_q;

  logic busy, blocked, acc, hit_busy, go, start_rd, start_wr, size_ok, launch, done, ctl_wr;

  assign busy     = (st != S_IDLE);
  assign blocked  = err_busy | err_bus;
  assign ctl_wr   = reg_valid && reg_write && reg_addr == 2'd0;
  assign acc      = reg_valid && ((reg_addr == 2'd1 && reg_write) || reg_addr == 2'd2);
  assign hit_busy = acc && busy;
  assign go       = acc && !busy && !blocked;
  assign start_rd = go && ((reg_addr == 2'd1 && reg_write && ctl_roa) ||
                           (reg_addr == 2'd2 && !reg_write && ctl_rod));
  assign start_wr = go && reg_addr == 2'd2 && reg_write;
  assign size_ok  = (ctl_size == SIZE_CODE);
  assign launch   = (start_rd || start_wr) && size_ok;
  assign done     = (st == S_WAIT) && mem_rsp_valid;

  assign mem_req   = (st == S_REQ);
  assign mem_we    = op_we;
  assign mem_addr  = req_addr;
  assign mem_wdata = data_q;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {21'd0, err_bus, err_busy, busy, 2'd0, ctl_inc, ctl_rod, ctl_roa, ctl_size};
      2'd1:    reg_rdata = 32'(addr_q);
      2'd2:    reg_rdata = 32'(data_q);
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ctl_size <= SIZE_CODE;
      ctl_roa  <= 1'b0;
      ctl_rod  <= 1'b0;
      ctl_inc  <= 1'b0;
      err_busy <= 1'b0;
      err_bus  <= 1'b0;
      op_we    <= 1'b0;
      addr_q   <= '0;
      req_addr <= '0;
      data_q   <= '0;
    end else begin
      if (ctl_wr) begin
        ctl_size <= reg_wdata[2:0];
        ctl_roa  <= reg_wdata[3];
        ctl_rod  <= reg_wdata[4];
        ctl_inc  <= reg_wdata[5];
        if (reg_wdata[9])  err_busy <= 1'b0;
        if (reg_wdata[10]) err_bus  <= 1'b0;
      end
      if (hit_busy) err_busy <= 1'b1;
      if (go && reg_addr == 2'd1) addr_q <= reg_wdata[AW-1:0];
      if (start_wr) data_q <= reg_wdata[DW-1:0];
      if ((start_rd || start_wr) && !size_ok) err_bus <= 1'b1;
      if (launch) begin
        st       <= S_REQ;
        op_we    <= start_wr;
        req_addr <= (reg_addr == 2'd1) ? reg_wdata[AW-1:0] : addr_q;
      end
      if (st == S_REQ && mem_ready) st <= S_WAIT;
      if (done) begin
        st <= S_IDLE;
        if (mem_rsp_err) err_bus <= 1'b1;
        else begin
          if (!op_we) data_q <= mem_rsp_data;
          if (ctl_inc) addr_q <= addr_q + AW'(STEP);
        end
      end
    end
  end
endmodule

module sba_engine_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_valid,
  input logic          reg_write,
  input logic [1:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_ready,
  input logic          mem_rsp_valid,
  input logic          mem_rsp_err,
  input logic          busy,
  input logic          err_busy,
  input logic          err_bus,
  input logic          ctl_inc,
  input logic [AW-1:0] addr_q
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R10
  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy); // R6
  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mem_req && mem_rsp_valid && !mem_rsp_err && ctl_inc |=> addr_q == $past(addr_q) + AW'(DW / 8)); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_bus && !(reg_valid && reg_write && reg_addr == 2'd0 && reg_wdata[10]) |=> err_bus); // R8
  AST_ERR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && (err_bus || err_busy) |=> !busy); // R7
  AST_BUSY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_valid && reg_write && reg_addr == 2'd1 |=> err_busy); // R7
endmodule

bind sba_engine sba_engine_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
  .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err), .busy(busy),
  .err_busy(err_busy), .err_bus(err_bus), .ctl_inc(ctl_inc), .addr_q(addr_q)
);

// File: tb/test_sba_engine.sv
module test_sba_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_valid = 1'b0, reg_write = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0, reg_rdata;
  logic mem_req, mem_we, mem_ready, rsp_v, rsp_err;
  logic [31:0] mem_addr, mem_wdata, rsp_d;
  logic [31:0] mem [16];
  logic [3:0] wcnt;
  int lat = 0;
  int nreq = 0;
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sba_engine i_sba_engine (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rsp_valid(rsp_v), .mem_rsp_data(rsp_d), .mem_rsp_err(rsp_err)
  );

  function automatic logic [31:0] pat(int i);
    return 32'h5A00_0000 + 32'(i) * 32'h0013_0071;
  endfunction

  assign mem_ready = mem_req && (wcnt == 4'(lat));

  always @(posedge clk) begin
    if (!rst_n) begin
      wcnt <= 4'd0; rsp_v <= 1'b0; rsp_err <= 1'b0; rsp_d <= 32'd0;
      for (int i = 0; i < 16; i++) mem[i] <= pat(i);
    end else begin
      rsp_v <= 1'b0;
      if (mem_req && !mem_ready) wcnt <= wcnt + 4'd1;
      if (mem_req && mem_ready) begin
        wcnt <= 4'd0; rsp_v <= 1'b1; rsp_err <= mem_addr[31];
        nreq <= nreq + 1;
        if (!mem_addr[31]) begin
          if (mem_we) mem[mem_addr[5:2]] <= mem_wdata;
          else rsp_d <= mem[mem_addr[5:2]];
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_valid = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int k = 0; k < 60; k++) begin
      host_rd(2'd0, v);
      if (!v[8]) return;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    host_rd(2'd0, v); chk("R1 ctrl", v, 32'h2);
    host_rd(2'd1, v); chk("R1 addr", v, 32'h0);
    host_rd(2'd2, v); chk("R1 data", v, 32'h0);
    chk("R1 req", 32'(mem_req), 32'h0);

    // R3: single reads on address write, no increment (R5)
    host_wr(2'd0, 32'h0000_000A);
    for (int i = 0; i < 16; i++) begin
      lat = i % 3;
      host_wr(2'd1, 32'(4 * i));
      wait_idle();
      host_rd(2'd2, v); chk("R3 data", v, pat(i));
      host_rd(2'd1, v); chk("R5 no inc", v, 32'(4 * i));
    end

    // R4/R5 streaming read, then R11
    lat = 1;
    host_wr(2'd0, 32'h0000_003A);
    host_wr(2'd1, 32'h0);
    wait_idle();
    for (int k = 0; k < 15; k++) begin
      host_rd(2'd2, v); chk("R4 stream", v, pat(k));
      wait_idle();
    end
    host_rd(2'd1, v); chk("R5 addr after stream", v, 32'd64);
    host_wr(2'd0, 32'h0000_0002);
    n0 = nreq;
    host_rd(2'd2, v); chk("R11 last word", v, pat(15));
    repeat (4) @(negedge clk);
    chk("R11 no cycle", 32'(nreq), 32'(n0));

    // R2 single writes, latency sweep
    for (int l = 0; l < 3; l++) begin
      lat = l;
      for (int i = 0; i < 16; i++) begin
        host_wr(2'd1, 32'(4 * i));
        host_wr(2'd2, 32'hC000_0000 + 32'(l * 256 + i));
        wait_idle();
        chk("R2 write", mem[i], 32'hC000_0000 + 32'(l * 256 + i));
      end
    end

    // R5 block write with increment
    lat = 0;
    host_wr(2'd0, 32'h0000_0022);
    host_wr(2'd1, 32'h0);
    for (int i = 0; i < 16; i++) begin
      host_wr(2'd2, 32'hB000_0000 ^ 32'(i * 7));
      wait_idle();
    end
    for (int i = 0; i < 16; i++) chk("R5 block", mem[i], 32'hB000_0000 ^ 32'(i * 7));
    host_rd(2'd1, v); chk("R5 addr after block", v, 32'd64);

    // R6 busy flag
    lat = 3;
    host_wr(2'd0, 32'h0000_0002);
    host_wr(2'd1, 32'h8);
    host_wr(2'd2, 32'h1234_5678);
    host_rd(2'd0, v); chk("R6 busy set", 32'(v[8]), 32'h1);
    wait_idle();
    host_rd(2'd0, v); chk("R6 busy clear", 32'(v[8]), 32'h0);

    // R7 access while busy
    host_wr(2'd2, 32'h0BAD_0001);
    host_wr(2'd1, 32'h20);
    wait_idle();
    host_rd(2'd0, v); chk("R7 flag", 32'(v[9]), 32'h1);
    host_rd(2'd1, v); chk("R7 dropped", v, 32'h8);
    n0 = nreq;
    host_wr(2'd2, 32'h0BAD_0002);
    repeat (6) @(negedge clk);
    chk("R7 blocked", 32'(nreq), 32'(n0));
    host_wr(2'd0, 32'h0000_0202);
    host_rd(2'd0, v); chk("R7 cleared", 32'(v[9]), 32'h0);

    // R8 error response
    lat = 0;
    host_wr(2'd0, 32'h0000_0022);
    host_wr(2'd1, 32'h8000_0000);
    host_rd(2'd2, v);
    host_wr(2'd2, 32'hDEAD_BEEF);
    wait_idle();
    host_rd(2'd0, v); chk("R8 flag", 32'(v[10]), 32'h1);
    host_rd(2'd1, v); chk("R8 no inc", v, 32'h8000_0000);
    n0 = nreq;
    host_wr(2'd1, 32'h4);
    host_rd(2'd1, v); chk("R8 blocked addr", v, 32'h8000_0000);
    chk("R8 no cycle", 32'(nreq), 32'(n0));
    host_wr(2'd0, 32'h0000_0402);
    host_rd(2'd0, v); chk("R8 cleared", 32'(v[10]), 32'h0);
    host_wr(2'd1, 32'h0);
    host_wr(2'd2, 32'h7777_0000);
    wait_idle();
    host_rd(2'd2, v); chk("R8 data held", v, 32'h7777_0000);

    // R9 bad size
    host_wr(2'd0, 32'h0000_0000);
    n0 = nreq;
    host_wr(2'd2, 32'h1111_1111);
    repeat (4) @(negedge clk);
    chk("R9 no cycle", 32'(nreq), 32'(n0));
    host_rd(2'd0, v); chk("R9 flag", 32'(v[10]), 32'h1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule